// File: doc/BRIEF.md
# Vertical Field Divider with Flywheel Lock

This block times vertical periods in units of scan lines and decides when the vertical retrace starts. It does not run from a free clock of its own. It advances by one position on each line-rate enable pulse, and it resynchronizes to trigger pulses that an upstream vertical sync separator delivers. After each retrace the position returns to zero. A trigger is only honoured if it arrives while the position lies inside the acceptance window of the current mode.

The block has two modes. In search mode the window is wide, so that any field rate in the catch range can be acquired. An RGB-source input lowers the window's lower limit, which admits faster field rates. Once enough consecutive triggers land inside a narrow window around the nominal field length, the block switches to standard mode. In standard mode only narrow-window triggers are accepted. If a trigger is missing, the block inserts a retrace itself at the narrow window's last line. A run of such insertions drops the block back to search mode.

In standard mode the block also raises an inhibit flag for the horizontal phase loop, a few lines either side of the expected field boundary, so that equalizing pulses do not disturb it. All limits are parameters counted in lines.

Top module: `vdiv_flywheel`

## Requirements
- R1: After reset `retrace_o`, `std_mode_o` and `phi_inhibit_o` are all 0 and the line position is 0.
- R2: The line position changes only on a clock with `line_en` high. It returns to 0 on a line that starts a retrace and otherwise increases by one. A trigger is judged on the line where `vsync_trig` is high, using the position held before that line. `retrace_o` is high for exactly one clock, the clock after that line.
- R3: In search mode with `rgb_mode` low, a trigger at a position from SRCH_LO (244) to SRCH_HI (350) inclusive starts a retrace. A trigger at any other position has no effect.
- R4: In search mode with `rgb_mode` high, the lower limit becomes SRCH_LO_RGB (219), so a trigger at position 230 starts a retrace. With `rgb_mode` low, that same trigger is ignored.
- R5: In search mode without an accepted trigger, a retrace is forced on the line at position SRCH_HI. The position never exceeds SRCH_HI.
- R6: An accepted search-mode trigger inside the narrow window (positions NARROW_LO 262 to NARROW_HI 264) counts as a hit. On the 16th consecutive hit, `std_mode_o` becomes 1, in the same clock as that retrace pulse.
- R7: In standard mode, a trigger outside the narrow window is ignored. A trigger inside it starts a retrace.
- R8: In standard mode without an accepted trigger, a retrace is inserted on the line at position NARROW_HI.
- R9: Six consecutive inserted retraces in standard mode return `std_mode_o` to 0 on the sixth one. An accepted trigger clears the count of consecutive insertions.
- R10: `phi_inhibit_o` is 1 exactly when `std_mode_o` is 1 and the position is at least NARROW_LO−EQ_LINES (253) or below EQ_LINES (9).
- R11: A search-mode retrace at a position outside the narrow window clears the count of consecutive hits. Fifteen further hits after it therefore leave the block in search mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_en | input | 1 | One-clock pulse per horizontal line |
| vsync_trig | input | 1 | Vertical trigger from the sync separator, sampled with `line_en` |
| rgb_mode | input | 1 | Widens the search window toward faster field rates |
| retrace_o | output | 1 | One-clock pulse that starts vertical retrace |
| std_mode_o | output | 1 | 1 in standard (narrow-window) mode, 0 in search mode |
| phi_inhibit_o | output | 1 | Inhibit for the horizontal phase loop around the field boundary |

## Verification
The hardest state to reach from the ports is the edge of the hysteresis counters. These are the fifteenth and sixteenth consecutive narrow hits, and the fifth and sixth consecutive insertions, together with the way an interrupting event resets them. The bench drives triggers at chosen positions, which it tracks with its own line model. It places a single wide-window trigger after fifteen hits, and a single narrow hit after five misses. This shows that the counts restart and do not carry over. Every clock is also compared against a behavioural reference model, so the position of each forced or inserted retrace is checked line by line.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;
   typedef enum logic {
      MODE_SEARCH   = 1'b0,
      MODE_STANDARD = 1'b1
   } vdiv_mode_e;
endpackage

// File: rtl/vdiv_line_counter.sv
module vdiv_line_counter #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             restart,
   output logic [CNT_W-1:0] pos
);
   always_ff @(posedge clk) begin
      if (!rst_n)       pos <= '0;
      else if (adv) begin
         if (restart)   pos <= '0;
         else           pos <= pos + CNT_W'(1);
      end
   end
endmodule

// File: rtl/vdiv_window_cmp.sv
module vdiv_window_cmp #(
   parameter int CNT_W       = 9,
   parameter int SRCH_LO     = 244,
   parameter int SRCH_LO_RGB = 219,
   parameter int SRCH_HI     = 350,
   parameter int NARROW_LO   = 262,
   parameter int NARROW_HI   = 264,
   parameter int EQ_LINES    = 9,
   parameter bit RGB_EN      = 1'b1
) (
   input  logic [CNT_W-1:0] pos,
   input  logic             rgb_mode,
   output logic             in_search,
   output logic             in_narrow,
   output logic             at_search_end,
   output logic             at_narrow_end,
   output logic             in_eq
);
   localparam logic [CNT_W-1:0] LO_STD  = CNT_W'(SRCH_LO);
   localparam logic [CNT_W-1:0] LO_RGB  = CNT_W'(SRCH_LO_RGB);
   localparam logic [CNT_W-1:0] HI_S    = CNT_W'(SRCH_HI);
   localparam logic [CNT_W-1:0] LO_N    = CNT_W'(NARROW_LO);
   localparam logic [CNT_W-1:0] HI_N    = CNT_W'(NARROW_HI);
   localparam logic [CNT_W-1:0] EQ_HEAD = CNT_W'(NARROW_LO - EQ_LINES);
   localparam logic [CNT_W-1:0] EQ_TAIL = CNT_W'(EQ_LINES);

   logic [CNT_W-1:0] lo_sel;

   generate
      if (RGB_EN) begin : g_rgb
         assign lo_sel = rgb_mode ? LO_RGB : LO_STD;
      end else begin : g_fixed
         logic unused_rgb;
         assign unused_rgb = rgb_mode;
         assign lo_sel     = LO_STD;
      end
   endgenerate

   always_comb begin
      in_search     = (pos >= lo_sel) && (pos <= HI_S);
      in_narrow     = (pos >= LO_N) && (pos <= HI_N);
      at_search_end = (pos == HI_S);
      at_narrow_end = (pos == HI_N);
      in_eq         = (pos >= EQ_HEAD) || (pos < EQ_TAIL);
   end
endmodule

// File: rtl/vdiv_mode_ctrl.sv
module vdiv_mode_ctrl
   import vdiv_pkg::*;
#(
   parameter int LOCK_HITS  = 16,
   parameter int MISS_LIMIT = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       evt,
   input  logic       hit_narrow,
   output vdiv_mode_e mode
);
   localparam int HIT_W  = $clog2(LOCK_HITS + 1);
   localparam int MISS_W = $clog2(MISS_LIMIT + 1);
   localparam logic [HIT_W-1:0]  HIT_LAST  = HIT_W'(LOCK_HITS - 1);
   localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 1);

   logic [HIT_W-1:0]  hits;
   logic [MISS_W-1:0] misses;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode   <= MODE_SEARCH;
         hits   <= '0;
         misses <= '0;
      end else if (evt) begin
         if (mode == MODE_SEARCH) begin
            misses <= '0;
            if (!hit_narrow) begin
               hits <= '0;
            end else if (hits == HIT_LAST) begin
               hits <= '0;
               mode <= MODE_STANDARD;
            end else begin
               hits <= hits + HIT_W'(1);
            end
         end else begin
            hits <= '0;
            if (hit_narrow) begin
               misses <= '0;
            end else if (misses == MISS_LAST) begin
               misses <= '0;
               mode   <= MODE_SEARCH;
            end else begin
               misses <= misses + MISS_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/vdiv_flywheel.sv
module vdiv_flywheel
   import vdiv_pkg::*;
#(
   parameter int SRCH_LO     = 244,
   parameter int SRCH_LO_RGB = 219,
   parameter int SRCH_HI     = 350,
   parameter int NARROW_LO   = 262,
   parameter int NARROW_HI   = 264,
   parameter int EQ_LINES    = 9,
   parameter int LOCK_HITS   = 16,
   parameter int MISS_LIMIT  = 6,
   parameter bit RGB_EN      = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_en,
   input  logic vsync_trig,
   input  logic rgb_mode,
   output logic retrace_o,
   output logic std_mode_o,
   output logic phi_inhibit_o
);
   localparam int CNT_W = $clog2(SRCH_HI + 1);

   generate
      if (SRCH_LO_RGB > SRCH_LO) begin : g_bad_rgb
         $error("widened lower limit must not exceed the normal one");
      end
      if (SRCH_LO > NARROW_LO || NARROW_HI > SRCH_HI) begin : g_bad_nest
         $error("narrow window must lie inside the search window");
      end
      if (NARROW_LO > NARROW_HI) begin : g_bad_narrow
         $error("narrow window limits reversed");
      end
      if (EQ_LINES < 1 || EQ_LINES >= NARROW_LO) begin : g_bad_eq
         $error("equalizing span out of range");
      end
      if (LOCK_HITS < 1 || MISS_LIMIT < 1) begin : g_bad_cnt
         $error("hit and miss limits must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] pos;
   logic             in_search, in_narrow, at_search_end, at_narrow_end, in_eq;
   logic             accept, insert, evt;
   vdiv_mode_e       mode;
   logic             std;

   assign std = (mode == MODE_STANDARD);

   vdiv_window_cmp #(
      .CNT_W(CNT_W), .SRCH_LO(SRCH_LO), .SRCH_LO_RGB(SRCH_LO_RGB),
      .SRCH_HI(SRCH_HI), .NARROW_LO(NARROW_LO), .NARROW_HI(NARROW_HI),
      .EQ_LINES(EQ_LINES), .RGB_EN(RGB_EN)
   ) u_win (
      .pos(pos), .rgb_mode(rgb_mode), .in_search(in_search),
      .in_narrow(in_narrow), .at_search_end(at_search_end),
      .at_narrow_end(at_narrow_end), .in_eq(in_eq)
   );

   always_comb begin
      accept = line_en && vsync_trig && (std ? in_narrow : in_search);
      insert = line_en && !accept && (std ? at_narrow_end : at_search_end);
      evt    = accept || insert;
   end

   vdiv_line_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .adv(line_en), .restart(evt), .pos(pos)
   );

   vdiv_mode_ctrl #(.LOCK_HITS(LOCK_HITS), .MISS_LIMIT(MISS_LIMIT)) u_mode (
      .clk(clk), .rst_n(rst_n), .evt(evt),
      .hit_narrow(accept && in_narrow), .mode(mode)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) retrace_o <= 1'b0;
      else        retrace_o <= evt;
   end

   assign std_mode_o    = std;
   assign phi_inhibit_o = std && in_eq;
endmodule

// File: rtl/vdiv_checks.sv
module vdiv_checks #(
   parameter int CNT_W       = 9,
   parameter int SRCH_LO_RGB = 219,
   parameter int SRCH_HI     = 350,
   parameter int NARROW_LO   = 262,
   parameter int NARROW_HI   = 264
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_en,
   input logic [CNT_W-1:0] pos,
   input logic             retrace_o,
   input logic             std_mode_o,
   input logic             phi_inhibit_o
);
   localparam logic [CNT_W-1:0] C_LO_RGB = CNT_W'(SRCH_LO_RGB);
   localparam logic [CNT_W-1:0] C_HI     = CNT_W'(SRCH_HI);
   localparam logic [CNT_W-1:0] C_NLO    = CNT_W'(NARROW_LO);
   localparam logic [CNT_W-1:0] C_NHI    = CNT_W'(NARROW_HI);

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pos <= C_HI);

   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      retrace_o |=> !retrace_o);

   p_pulse_after_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
      retrace_o |-> $past(line_en));

   p_search_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (retrace_o && !$past(std_mode_o)) |->
         ($past(pos) >= C_LO_RGB && $past(pos) <= C_HI));

   p_std_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (retrace_o && $past(std_mode_o)) |->
         ($past(pos) >= C_NLO && $past(pos) <= C_NHI));

   p_mode_on_retrace_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(std_mode_o) |-> retrace_o);

   p_inhibit_in_std_r10: assert property (@(posedge clk) disable iff (!rst_n)
      phi_inhibit_o |-> std_mode_o);
endmodule

bind vdiv_flywheel vdiv_checks #(
   .CNT_W(CNT_W), .SRCH_LO_RGB(SRCH_LO_RGB), .SRCH_HI(SRCH_HI),
   .NARROW_LO(NARROW_LO), .NARROW_HI(NARROW_HI)
) u_checks (
   .clk(clk), .rst_n(rst_n), .line_en(line_en), .pos(pos),
   .retrace_o(retrace_o), .std_mode_o(std_mode_o),
   .phi_inhibit_o(phi_inhibit_o)
);

// File: tb/vdiv_flywheel_test.sv
`timescale 1ns/1ps
module vdiv_flywheel_test;
   localparam int LO = 244, LO_RGB = 219, HI = 350;
   localparam int NLO = 262, NHI = 264, EQ = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_en = 1'b0, vsync_trig = 1'b0, rgb_mode = 1'b0;
   logic retrace_o, std_mode_o, phi_inhibit_o;
   int   vectors = 0, miscompares = 0;

   always #10 clk = ~clk;

   vdiv_flywheel #(
      .SRCH_LO(LO), .SRCH_LO_RGB(LO_RGB), .SRCH_HI(HI),
      .NARROW_LO(NLO), .NARROW_HI(NHI), .EQ_LINES(EQ),
      .LOCK_HITS(16), .MISS_LIMIT(6), .RGB_EN(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .line_en(line_en), .vsync_trig(vsync_trig),
      .rgb_mode(rgb_mode), .retrace_o(retrace_o), .std_mode_o(std_mode_o),
      .phi_inhibit_o(phi_inhibit_o)
   );

   // behavioural reference model
   int m_pos = 0, m_hits = 0, m_miss = 0;
   bit m_std = 0, m_ret = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = 0; m_hits = 0; m_miss = 0; m_std = 0; m_ret = 0;
      end else begin
         m_ret = 0;
         if (line_en) begin
            int  lo;
            bit  narrow, acc, ins;
            lo     = rgb_mode ? LO_RGB : LO;
            narrow = (m_pos >= NLO && m_pos <= NHI);
            acc    = vsync_trig && (m_std ? narrow : (m_pos >= lo && m_pos <= HI));
            ins    = !acc && (m_std ? (m_pos == NHI) : (m_pos == HI));
            if (acc || ins) begin
               m_ret = 1;
               if (!m_std) begin
                  if (acc && narrow) begin
                     m_hits++;
                     if (m_hits > 15) begin m_std = 1; m_hits = 0; end
                  end else m_hits = 0;
               end else begin
                  if (acc) m_miss = 0;
                  else begin
                     m_miss++;
                     if (m_miss == 6) begin m_std = 0; m_miss = 0; end
                  end
               end
               m_pos = 0;
            end else m_pos++;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit exp_inh;
         exp_inh = m_std && (m_pos >= NLO - EQ || m_pos < EQ);
         vectors++;
         if (retrace_o !== m_ret) begin
            miscompares++;
            $display("FAIL R2 R3 R5 R8 retrace at pos %0d: actual=%b expected=%b", m_pos, retrace_o, m_ret);
         end
         if (std_mode_o !== m_std) begin
            miscompares++;
            $display("FAIL R6 R9 mode: actual=%b expected=%b", std_mode_o, m_std);
         end
         if (phi_inhibit_o !== exp_inh) begin
            miscompares++;
            $display("FAIL R10 inhibit at pos %0d: actual=%b expected=%b", m_pos, phi_inhibit_o, exp_inh);
         end
      end
   end

   task automatic chk(input logic act, input logic exp, input string tag);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic tick(input logic t, output logic r);
      @(negedge clk);
      line_en = 1'b1; vsync_trig = t;
      @(negedge clk);
      r = retrace_o;
      line_en = 1'b0; vsync_trig = 1'b0;
   endtask

   task automatic go_to(input int k, input logic t, output logic r);
      logic d;
      while (m_pos != k) tick(1'b0, d);
      tick(t, r);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(retrace_o, 1'b0, "R1 retrace after reset");
      chk(std_mode_o, 1'b0, "R1 mode after reset");
      chk(phi_inhibit_o, 1'b0, "R1 inhibit after reset");

      go_to(100, 1'b1, r);  chk(r, 1'b0, "R3 early trigger ignored");
      go_to(300, 1'b1, r);  chk(r, 1'b1, "R3 trigger in wide window");
      go_to(HI, 1'b0, r);   chk(r, 1'b1, "R5 forced retrace at upper limit");

      rgb_mode = 1'b1;
      go_to(230, 1'b1, r);  chk(r, 1'b1, "R4 widened window accepts 230");
      rgb_mode = 1'b0;
      go_to(230, 1'b1, r);  chk(r, 1'b0, "R4 normal window rejects 230");
      go_to(HI, 1'b0, r);   chk(r, 1'b1, "R5 forced retrace again");

      for (int i = 0; i < 15; i++) go_to(263, 1'b1, r);
      chk(std_mode_o, 1'b0, "R6 still searching after 15 hits");
      go_to(300, 1'b1, r);  chk(r, 1'b1, "R11 wide hit accepted");
      for (int i = 0; i < 15; i++) go_to(263, 1'b1, r);
      chk(std_mode_o, 1'b0, "R11 hit count restarted");
      go_to(263, 1'b1, r);
      chk(std_mode_o, 1'b1, "R6 standard mode on 16th hit");
      chk(phi_inhibit_o, 1'b1, "R10 inhibit right after boundary");

      go_to(250, 1'b1, r);  chk(r, 1'b0, "R7 trigger outside narrow ignored");
      go_to(251, 1'b0, r);  chk(phi_inhibit_o, 1'b0, "R10 no inhibit at 252");
      tick(1'b0, r);        chk(phi_inhibit_o, 1'b1, "R10 inhibit at 253");
      go_to(263, 1'b1, r);  chk(r, 1'b1, "R7 narrow trigger accepted");

      for (int i = 0; i < 5; i++) begin
         go_to(NHI, 1'b0, r);
         chk(r, 1'b1, "R8 inserted retrace at window end");
      end
      chk(std_mode_o, 1'b1, "R9 five misses keep standard mode");
      go_to(NLO, 1'b1, r);  chk(r, 1'b1, "R9 hit clears misses");
      for (int i = 0; i < 5; i++) go_to(NHI, 1'b0, r);
      chk(std_mode_o, 1'b1, "R9 miss count restarted");
      go_to(NHI, 1'b0, r);
      chk(std_mode_o, 1'b0, "R9 sixth miss returns to search");
      go_to(HI, 1'b0, r);   chk(r, 1'b1, "R5 search limit after fallback");

      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule